// File: doc/BRIEF.md
# Bidirectional inter-processor FIFO mailbox

This block carries 32-bit words between two processors, called side A and side B. Each direction has its own 16-entry queue. A side writes words into its send queue, and the other side reads them from its receive port. Each side has a 16-bit control/status register. That register shows the state of the side's own send queue and the state of the queue arriving from the peer. Through it a side enables its port, arms its two interrupts, flushes its send queue and clears its error flag.

Each side has two interrupt pulses. One says that the side's send queue has just become empty. The other says that its receive queue holds data. Either pulse also fires when software arms it while its condition already holds. Overflow and underflow set a sticky error flag for the offending side. Bus decoding and the interrupt controller sit outside the block. A write strobe and a read strobe per side stand in for the bus cycles.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, the latched receive words are 0 and no interrupt is asserted. Each side's status reads 0x0101.
- R2: The status register bits are as follows: bit 0 send queue empty, bit 1 send queue full, bit 2 send-empty interrupt enable, bit 8 receive queue empty, bit 9 receive queue full, bit 10 receive-ready interrupt enable, bit 14 error, bit 15 port enable. All other bits read 0. A control write changes only bits 2, 10 and 15 directly.
- R3: Each queue delivers words in the order they were written and holds 16 words. A send write is accepted only while the sender's bit 15 is 1. A write made with bit 15 at 0 changes nothing.
- R4: A send write to a queue that already holds 16 words drops the word and sets the sender's error bit.
- R5: A read strobe on a non-empty receive queue latches the head word onto the receive data port from the next cycle. The word is removed only if the reader's bit 15 is 1. Otherwise it stays at the head.
- R6: A read strobe on an empty receive queue sets the reader's error bit and leaves the receive data port unchanged.
- R7: A control write with bit 14 at 1 clears the error bit. If an error occurs in the same cycle, the error bit stays set.
- R8: A control write with bit 3 at 1 while the send queue is non-empty has these effects: the queue is emptied, the peer's latched receive word becomes 0, and both empty flags are set and both full flags cleared. A send-empty pulse follows if bit 2 was already 1. With an empty queue, bit 3 has no effect.
- R9: An accepted write into an empty queue raises the receiver's receive-ready pulse if the receiver's bit 10 is 1.
- R10: A read that removes the last word raises the sender's send-empty pulse if the sender's bit 2 is 1.
- R11: A control write that sets bit 2 from 0 while the send queue is empty raises the send-empty pulse. A write that sets bit 10 from 0 while the receive queue is non-empty raises the receive-ready pulse.
- R12: Interrupt outputs are one-cycle pulses, asserted in the cycle after the triggering strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ctl_we | input | 1 | Side A control register write strobe |
| a_ctl_wdata | input | 16 | Side A control write data |
| a_ctl_rdata | output | 16 | Side A status/control read value |
| a_tx_we | input | 1 | Side A send-data write strobe |
| a_tx_data | input | 32 | Side A send word |
| a_rx_re | input | 1 | Side A receive read strobe |
| a_rx_data | output | 32 | Side A latched receive word |
| a_irq_tx_empty | output | 1 | Side A send-empty interrupt pulse |
| a_irq_rx_ready | output | 1 | Side A receive-ready interrupt pulse |
| b_ctl_we | input | 1 | Side B control register write strobe |
| b_ctl_wdata | input | 16 | Side B control write data |
| b_ctl_rdata | output | 16 | Side B status/control read value |
| b_tx_we | input | 1 | Side B send-data write strobe |
| b_tx_data | input | 32 | Side B send word |
| b_rx_re | input | 1 | Side B receive read strobe |
| b_rx_data | output | 32 | Side B latched receive word |
| b_irq_tx_empty | output | 1 | Side B send-empty interrupt pulse |
| b_irq_rx_ready | output | 1 | Side B receive-ready interrupt pulse |

## Verification
The hardest case to reach is an error that arrives in the same cycle as its write-1-to-clear. The bench drives an underflow read and an error-clearing control write on the same edge and then expects the flag to remain set. The flush-with-latched-word case also needs setup first. The bench fills the queue, disables the reader so that it peeks without removing, re-enables it, consumes one word and then flushes, which shows the peer's receive port dropping to zero. Full-depth fills and drains in both directions sweep every queue count, and the flags are checked after each step.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned CTL_W        = 16;
  localparam int unsigned B_TX_EMPTY   = 0;
  localparam int unsigned B_TX_FULL    = 1;
  localparam int unsigned B_TX_IE      = 2;
  localparam int unsigned B_FLUSH      = 3;
  localparam int unsigned B_RX_EMPTY   = 8;
  localparam int unsigned B_RX_FULL    = 9;
  localparam int unsigned B_RX_IE      = 10;
  localparam int unsigned B_ERR        = 14;
  localparam int unsigned B_EN         = 15;
endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         first_o,
  output logic         drained_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign head      = mem[rd_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign first_o   = do_push && empty;
  assign drained_o = do_pop && !do_push && (cnt_q == CW'(1));

  assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !flush) |=> $stable(cnt_q));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/ipc_cpu_port.sv
module ipc_cpu_port
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             tx_we,
  input  logic             rx_re,
  output logic [W-1:0]     rx_data,
  input  logic             send_empty,
  input  logic             send_full,
  input  logic             recv_empty,
  input  logic             recv_full,
  input  logic [W-1:0]     recv_head,
  input  logic             send_drained,
  input  logic             recv_first,
  input  logic             peer_flush,
  output logic             push_o,
  output logic             pop_o,
  output logic             flush_o,
  output logic             irq_tx_empty,
  output logic             irq_rx_ready
);
  logic         en_q, ie_tx_q, ie_rx_q, err_q, itx_q, irx_q;
  logic         en_n, ie_tx_n, ie_rx_n, err_n, itx_n, irx_n;
  logic [W-1:0] rx_q, rx_n;
  logic         tx_err, rx_err, peek;

  always_comb begin
    flush_o = ctl_we && ctl_wdata[B_FLUSH] && !send_empty;
    push_o  = tx_we && en_q && !send_full && !flush_o;
    tx_err  = tx_we && en_q && send_full;
    peek    = rx_re && !recv_empty;
    pop_o   = peek && en_q && !peer_flush;
    rx_err  = rx_re && recv_empty;

    en_n    = ctl_we ? ctl_wdata[B_EN]    : en_q;
    ie_tx_n = ctl_we ? ctl_wdata[B_TX_IE] : ie_tx_q;
    ie_rx_n = ctl_we ? ctl_wdata[B_RX_IE] : ie_rx_q;

    err_n = err_q;
    if (ctl_we && ctl_wdata[B_ERR]) err_n = 1'b0;
    if (tx_err || rx_err)           err_n = 1'b1;

    rx_n = rx_q;
    if (peer_flush)  rx_n = '0;
    else if (peek)   rx_n = recv_head;

    itx_n = (flush_o && ie_tx_q)
         || (ctl_we && !ie_tx_q && ctl_wdata[B_TX_IE] && (send_empty || flush_o))
         || (send_drained && ie_tx_q);
    irx_n = (ctl_we && !ie_rx_q && ctl_wdata[B_RX_IE] && !recv_empty)
         || (recv_first && ie_rx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ie_tx_q <= 1'b0;
      ie_rx_q <= 1'b0;
      err_q   <= 1'b0;
      itx_q   <= 1'b0;
      irx_q   <= 1'b0;
      rx_q    <= '0;
    end else begin
      en_q    <= en_n;
      ie_tx_q <= ie_tx_n;
      ie_rx_q <= ie_rx_n;
      err_q   <= err_n;
      itx_q   <= itx_n;
      irx_q   <= irx_n;
      rx_q    <= rx_n;
    end
  end

  always_comb begin
    ctl_rdata             = '0;
    ctl_rdata[B_TX_EMPTY] = send_empty;
    ctl_rdata[B_TX_FULL]  = send_full;
    ctl_rdata[B_TX_IE]    = ie_tx_q;
    ctl_rdata[B_RX_EMPTY] = recv_empty;
    ctl_rdata[B_RX_FULL]  = recv_full;
    ctl_rdata[B_RX_IE]    = ie_rx_q;
    ctl_rdata[B_ERR]      = err_q;
    ctl_rdata[B_EN]       = en_q;
  end

  assign rx_data      = rx_q;
  assign irq_tx_empty = itx_q;
  assign irq_rx_ready = irx_q;

  assert_overflow_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && en_q && send_full) |=> err_q);
  assert_underflow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_re && recv_empty && !peer_flush) |=> (err_q && rx_data == $past(rx_data)));
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[B_ERR] && !tx_we && !rx_re) |=> !err_q);
  assert_drain_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (send_drained && ie_tx_q) |=> irq_tx_empty);
  assert_first_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_first && ie_rx_q) |=> irq_rx_ready);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_ctl_we,
  input  logic [CTL_W-1:0] a_ctl_wdata,
  output logic [CTL_W-1:0] a_ctl_rdata,
  input  logic             a_tx_we,
  input  logic [W-1:0]     a_tx_data,
  input  logic             a_rx_re,
  output logic [W-1:0]     a_rx_data,
  output logic             a_irq_tx_empty,
  output logic             a_irq_rx_ready,
  input  logic             b_ctl_we,
  input  logic [CTL_W-1:0] b_ctl_wdata,
  output logic [CTL_W-1:0] b_ctl_rdata,
  input  logic             b_tx_we,
  input  logic [W-1:0]     b_tx_data,
  input  logic             b_rx_re,
  output logic [W-1:0]     b_rx_data,
  output logic             b_irq_tx_empty,
  output logic             b_irq_rx_ready
);
  localparam int unsigned SIDES = 2;

  logic             ctl_we  [SIDES];
  logic [CTL_W-1:0] ctl_wd  [SIDES];
  logic [CTL_W-1:0] ctl_rd  [SIDES];
  logic             tx_we   [SIDES];
  logic [W-1:0]     tx_data [SIDES];
  logic             rx_re   [SIDES];
  logic [W-1:0]     rx_data [SIDES];
  logic             irq_tx  [SIDES];
  logic             irq_rx  [SIDES];
  logic             push    [SIDES];
  logic             pop     [SIDES];
  logic             flush   [SIDES];
  logic [W-1:0]     head    [SIDES];
  logic             empty   [SIDES];
  logic             full    [SIDES];
  logic             first   [SIDES];
  logic             drained [SIDES];

  assign ctl_we[0]  = a_ctl_we;     assign ctl_we[1]  = b_ctl_we;
  assign ctl_wd[0]  = a_ctl_wdata;  assign ctl_wd[1]  = b_ctl_wdata;
  assign tx_we[0]   = a_tx_we;      assign tx_we[1]   = b_tx_we;
  assign tx_data[0] = a_tx_data;    assign tx_data[1] = b_tx_data;
  assign rx_re[0]   = a_rx_re;      assign rx_re[1]   = b_rx_re;
  assign a_ctl_rdata    = ctl_rd[0];  assign b_ctl_rdata    = ctl_rd[1];
  assign a_rx_data      = rx_data[0]; assign b_rx_data      = rx_data[1];
  assign a_irq_tx_empty = irq_tx[0];  assign b_irq_tx_empty = irq_tx[1];
  assign a_irq_rx_ready = irq_rx[0];  assign b_irq_rx_ready = irq_rx[1];

  // Queue g carries words sent by side g; side 1-g reads it.
  for (genvar g = 0; g < SIDES; g++) begin : g_side
    ipc_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[g]),
      .push_data (tx_data[g]),
      .pop       (pop[1-g]),
      .flush     (flush[g]),
      .head      (head[g]),
      .empty     (empty[g]),
      .full      (full[g]),
      .first_o   (first[g]),
      .drained_o (drained[g])
    );

    ipc_cpu_port #(.W(W)) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we[g]),
      .ctl_wdata    (ctl_wd[g]),
      .ctl_rdata    (ctl_rd[g]),
      .tx_we        (tx_we[g]),
      .rx_re        (rx_re[g]),
      .rx_data      (rx_data[g]),
      .send_empty   (empty[g]),
      .send_full    (full[g]),
      .recv_empty   (empty[1-g]),
      .recv_full    (full[1-g]),
      .recv_head    (head[1-g]),
      .send_drained (drained[g]),
      .recv_first   (first[1-g]),
      .peer_flush   (flush[1-g]),
      .push_o       (push[g]),
      .pop_o        (pop[g]),
      .flush_o      (flush[g]),
      .irq_tx_empty (irq_tx[g]),
      .irq_rx_ready (irq_rx[g])
    );
  end

  assert_flags_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctl_rdata[B_TX_EMPTY] == b_ctl_rdata[B_RX_EMPTY])
    && (b_ctl_rdata[B_TX_FULL] == a_ctl_rdata[B_RX_FULL]));
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we [2];
  logic [15:0] ctl_wd [2];
  logic [15:0] ctl_rd [2];
  logic        tx_we  [2];
  logic [31:0] tx_d   [2];
  logic        rx_re  [2];
  logic [31:0] rx_d   [2];
  logic        itx    [2];
  logic        irx    [2];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_ctl_we(ctl_we[0]), .a_ctl_wdata(ctl_wd[0]), .a_ctl_rdata(ctl_rd[0]),
    .a_tx_we(tx_we[0]), .a_tx_data(tx_d[0]), .a_rx_re(rx_re[0]), .a_rx_data(rx_d[0]),
    .a_irq_tx_empty(itx[0]), .a_irq_rx_ready(irx[0]),
    .b_ctl_we(ctl_we[1]), .b_ctl_wdata(ctl_wd[1]), .b_ctl_rdata(ctl_rd[1]),
    .b_tx_we(tx_we[1]), .b_tx_data(tx_d[1]), .b_rx_re(rx_re[1]), .b_rx_data(rx_d[1]),
    .b_irq_tx_empty(itx[1]), .b_irq_rx_ready(irx[1])
  );

  function automatic logic [31:0] word(int s, int k);
    return 32'h1000_0000 * (s + 1) + 32'h0001_0203 * k;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(int s, logic [15:0] v);
    ctl_we[s] = 1'b1; ctl_wd[s] = v;
    @(negedge clk);
    ctl_we[s] = 1'b0; ctl_wd[s] = '0;
  endtask

  task automatic push(int s, logic [31:0] v);
    tx_we[s] = 1'b1; tx_d[s] = v;
    @(negedge clk);
    tx_we[s] = 1'b0;
  endtask

  task automatic rd(int s);
    rx_re[s] = 1'b1;
    @(negedge clk);
    rx_re[s] = 1'b0;
  endtask

  task automatic idle_quiet(string tag);
    @(negedge clk);
    chk(tag, {itx[0], irx[0], itx[1], irx[1]}, 4'b0000);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      ctl_we[s] = 0; ctl_wd[s] = 0; tx_we[s] = 0; tx_d[s] = 0; rx_re[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a status", ctl_rd[0], 16'h0101);
    chk("R1 b status", ctl_rd[1], 16'h0101);
    chk("R1 rx data", {rx_d[0] | rx_d[1]}, 32'h0);
    chk("R1 irq", {itx[0], irx[0], itx[1], irx[1]}, 4'b0000);

    // R11 arming send-empty while empty fires; R2 bit layout
    ctl(0, 16'h8004);
    chk("R11 a tx arm", itx[0], 1'b1);
    chk("R2 a status", ctl_rd[0], 16'h8105);
    idle_quiet("R12 pulse width");
    ctl(1, 16'h8400);
    chk("R11 b rx arm on empty", irx[1], 1'b0);
    chk("R2 b status", ctl_rd[1], 16'h8501);

    // R3 fill A->B, R9 first word irq
    for (int k = 1; k <= 16; k++) begin
      push(0, word(0, k));
      chk("R3 a fill status", ctl_rd[0], 16'h8104 | (k == 16 ? 16'h0002 : 16'h0));
      chk("R2 b mirror", ctl_rd[1], 16'h8401 | (k == 16 ? 16'h0200 : 16'h0));
      chk("R9 b rx irq", irx[1], (k == 1));
    end
    push(0, 32'hDEAD_BEEF);
    chk("R4 overflow err", ctl_rd[0], 16'hC106);
    ctl(0, 16'hC004);
    chk("R7 err clear", ctl_rd[0], 16'h8106);
    chk("R11 no rearm", itx[0], 1'b0);

    // R5 drain in order, R10 drain irq
    for (int k = 1; k <= 16; k++) begin
      rd(1);
      chk("R5 order", rx_d[1], word(0, k));
      chk("R2 a drain status", ctl_rd[0], 16'h8104 | (k == 16 ? 16'h0001 : 16'h0));
      chk("R2 b drain status", ctl_rd[1], 16'h8401 | (k == 16 ? 16'h0100 : 16'h0));
      chk("R10 a tx irq", itx[0], (k == 16));
    end
    rd(1);
    chk("R6 underflow err", ctl_rd[1], 16'hC501);
    chk("R6 rx unchanged", rx_d[1], word(0, 16));

    // R5 peek with reader disabled
    ctl(1, 16'h0000);
    push(0, 32'hCAFE_0001);
    chk("R9 no irq when off", irx[1], 1'b0);
    rd(1);
    chk("R5 peek data", rx_d[1], 32'hCAFE_0001);
    rd(1);
    chk("R5 peek kept", ctl_rd[0], 16'h8104);
    ctl(1, 16'hC400);
    chk("R11 b rx arm nonempty", irx[1], 1'b1);
    chk("R7 b err cleared", ctl_rd[1], 16'h8401);

    // R8 flush
    push(0, 32'hCAFE_0002);
    push(0, 32'hCAFE_0003);
    rd(1);
    chk("R5 pop latch", rx_d[1], 32'hCAFE_0001);
    ctl(0, 16'h800C);
    chk("R8 flush irq", itx[0], 1'b1);
    chk("R8 a status", ctl_rd[0], 16'h8105);
    chk("R8 b status", ctl_rd[1], 16'h8501);
    chk("R8 peer latch zero", rx_d[1], 32'h0);
    ctl(0, 16'h800C);
    chk("R8 flush empty no irq", itx[0], 1'b0);

    // B->A direction
    ctl(1, 16'h8000);
    ctl(0, 16'h8400);
    for (int k = 1; k <= 16; k++) begin
      push(1, word(1, k));
      chk("R9 a rx irq", irx[0], (k == 1));
      chk("R3 a recv flags", ctl_rd[0], 16'h8401 | (k == 16 ? 16'h0200 : 16'h0));
    end
    for (int k = 1; k <= 16; k++) begin
      rd(0);
      chk("R5 b->a order", rx_d[0], word(1, k));
      chk("R10 disarmed", itx[1], 1'b0);
    end
    chk("R2 b empty again", ctl_rd[1], 16'h8101);

    // R7 error set wins over same-cycle clear
    rx_re[0] = 1'b1; ctl_we[0] = 1'b1; ctl_wd[0] = 16'hC400;
    @(negedge clk);
    rx_re[0] = 1'b0; ctl_we[0] = 1'b0; ctl_wd[0] = '0;
    chk("R7 set wins", ctl_rd[0][14], 1'b1);
    ctl(0, 16'hC400);
    chk("R7 clear after", ctl_rd[0][14], 1'b0);

    // R3 disabled sender ignored
    ctl(1, 16'h0000);
    push(1, 32'h1234_5678);
    chk("R3 ignored push b", ctl_rd[1], 16'h0101);
    chk("R3 ignored no irq", irx[0], 1'b0);
    chk("R3 ignored a view", ctl_rd[0][8], 1'b1);
    idle_quiet("R12 quiet end");

    done = 1'b1;
    summary();
  end
endmodule